// File: doc/BRIEF.md
# Sleep-Mode External Wakeup Controller

This block brings a small microcontroller out of a deep retention sleep in which the main oscillator is stopped. It runs only on an always-on sampling clock and reacts only to external pins, never to timers. Two styles of wakeup sit side by side. The two 4-bit key ports feed one shared falling-edge detector, and each pin takes part only if its enable bit is set. Each interrupt pin wakes the device when it sits at a programmed level.

Software sets up the block from the accumulator. A 3-bit select picks one 4-bit register to write or read back. The registers are the key enables for each port, the pull-up enables for each port, and one control register per interrupt pin. During normal run the interrupt pins set their request flags on the edge chosen by their control register. During sleep the level wakeup leaves those flags untouched. The wakeup request stays high until the sleep controller acknowledges it.

Top module: `wake_ctrl`

## Requirements
- R1: After reset, every key enable, pull-up and interrupt control bit is 0, `wakeReq` is 0 and `exfFlag` is 0.
- R2: With `regWr` high, `accIn` is written to the register picked by `regSel`: 0 = port A key enables, 1 = port B key enables, 2 = port A pull-ups, 3 = port B pull-ups, 4 = pin 0 control, 5 = pin 1 control. `accOut` returns that register's value at once. Codes 6 and 7 read as 0, and a write with them changes nothing.
- R3: `pullEn[3:0]` equals the port A pull-up register and `pullEn[7:4]` equals the port B pull-up register.
- R4: In sleep, a high-to-low transition on a key pin whose enable bit is 1 raises `wakeReq`. It is visible at most 4 sampling cycles after the pin changes.
- R5: In sleep, a low-to-high transition on an enabled key pin does not raise `wakeReq`.
- R6: In sleep, transitions on a key pin whose enable bit is 0 are ignored.
- R7: All enabled key pins share one falling-edge detector that watches the AND of the enabled pins. While any enabled pin is low, a fall on another enabled pin does not wake.
- R8: In sleep, interrupt pin i wakes the device while its synchronized level equals bit 2 of its control register (1 = high, 0 = low). This holds for both pins and both polarities.
- R9: A level wakeup does not set `exfFlag`, either during sleep or on return to run.
- R10: In run mode, neither a key edge nor an interrupt level raises `wakeReq`. Sleep is entered by a one-cycle pulse on `sleepEnter`.
- R11: `wakeReq` stays high until `wakeAck` is sampled high. After that it is low on the next cycle and the block is back in run mode.
- R12: In run mode, an edge on interrupt pin i sets `exfFlag[i]`. The edge is rising when control bit 2 is 1 and falling when it is 0. The opposite edge does not set it, and `exfClr[i]` clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sampleClk | input | 1 | Always-on sampling clock |
| rstN | input | 1 | Asynchronous active-low reset |
| keyPortA | input | 4 | Key port A pins (asynchronous) |
| keyPortB | input | 4 | Key port B pins (asynchronous) |
| intPin | input | 2 | Interrupt pins 0 and 1 (asynchronous) |
| regWr | input | 1 | Register write strobe from the accumulator |
| regSel | input | 3 | Register select code |
| accIn | input | 4 | Accumulator write data |
| accOut | output | 4 | Read-back data for the selected register |
| exfClr | input | 2 | Per-pin clear of the interrupt request flags |
| sleepEnter | input | 1 | One-cycle strobe that enters sleep |
| wakeAck | input | 1 | Sleep controller acknowledge of the wakeup |
| wakeReq | output | 1 | Wakeup request, held until acknowledged |
| pullEn | output | 8 | Pull-up enables, port B in the upper nibble |
| exfFlag | output | 2 | Interrupt request flags |

## Verification
The bench builds the block with its defaults: 4-bit key ports, two interrupt pins, a 4-bit accumulator and a two-stage synchronizer. With these values every select code is reachable, including the two unused ones. Both ports, both interrupt pins and both polarities on each pin can be exercised, so the shared-detector masking and the separation between flag and level wakeup are covered on every pin.

// File: rtl/wk_pkg.sv
package wk_pkg;
  typedef enum logic [2:0] {
    SEL_KEYEN_A = 3'd0,
    SEL_KEYEN_B = 3'd1,
    SEL_PULL_A  = 3'd2,
    SEL_PULL_B  = 3'd3,
    SEL_INTC0   = 3'd4
  } regSel_e;

  typedef enum logic [1:0] {
    ST_RUN   = 2'd0,
    ST_SLEEP = 2'd1,
    ST_WAKE  = 2'd2
  } wkState_e;

  // control -> datapath strobes
  typedef struct packed {
    logic armed;    // sleep active, wakeup logic armed
    logic runMode;  // normal run, edge flags may set
  } wkStrobe_t;
endpackage

// File: rtl/wk_sync.sv
module wk_sync #(
  parameter int   WIDTH   = 1,
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  localparam int CHAIN_W = WIDTH * STAGES;

  logic [CHAIN_W-1:0] chain;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) chain <= {CHAIN_W{RST_VAL}};
    else       chain <= {chain[CHAIN_W-WIDTH-1:0], d};
  end

  assign q = chain[CHAIN_W-1 -: WIDTH];
endmodule

// File: rtl/wk_datapath.sv
module wk_datapath
  import wk_pkg::*;
#(
  parameter int KEY_W       = 4,
  parameter int NUM_INT     = 2,
  parameter int ACC_W       = 4,
  parameter int LEVEL_BIT   = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [KEY_W-1:0]   keyA,
  input  logic [KEY_W-1:0]   keyB,
  input  logic [NUM_INT-1:0] intPin,
  input  logic               regWr,
  input  logic [2:0]         regSel,
  input  logic [ACC_W-1:0]   accIn,
  input  logic [NUM_INT-1:0] exfClr,
  input  wkStrobe_t          strobes,
  output logic [ACC_W-1:0]   accOut,
  output logic [2*KEY_W-1:0] pullEn,
  output logic [NUM_INT-1:0] exfFlag,
  output logic               wakeHit
);
  localparam int KEYS_W   = 2 * KEY_W;
  localparam int SEL_W    = 3;
  localparam int INT_BASE = 4;

  // configuration registers
  logic [KEY_W-1:0] keyEnA, keyEnB, pullA, pullB;
  logic [ACC_W-1:0] intCtrl [NUM_INT];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      keyEnA <= '0;
      keyEnB <= '0;
      pullA  <= '0;
      pullB  <= '0;
    end else if (regWr) begin
      if (regSel == SEL_KEYEN_A) keyEnA <= accIn[KEY_W-1:0];
      if (regSel == SEL_KEYEN_B) keyEnB <= accIn[KEY_W-1:0];
      if (regSel == SEL_PULL_A)  pullA  <= accIn[KEY_W-1:0];
      if (regSel == SEL_PULL_B)  pullB  <= accIn[KEY_W-1:0];
    end
  end

  assign pullEn = {pullB, pullA};

  // synchronizers
  logic [KEYS_W-1:0]  keySync;
  logic [NUM_INT-1:0] intSync;

  wk_sync #(.WIDTH(KEYS_W), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_keySync (
    .clk(clk), .rstN(rstN), .d({keyB, keyA}), .q(keySync)
  );

  wk_sync #(.WIDTH(NUM_INT), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_intSync (
    .clk(clk), .rstN(rstN), .d(intPin), .q(intSync)
  );

  // shared falling-edge detector over the AND of enabled key pins
  logic [KEYS_W-1:0] keyEn;
  logic keyLine, keyLinePrev, keyFall;

  assign keyEn   = {keyEnB, keyEnA};
  assign keyLine = &(keySync | ~keyEn);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) keyLinePrev <= 1'b1;
    else       keyLinePrev <= keyLine;
  end

  assign keyFall = keyLinePrev & ~keyLine;

  // interrupt pins: control register, level match, edge flag
  logic [NUM_INT-1:0] levelHit;

  genvar gi;
  generate
    for (gi = 0; gi < NUM_INT; gi++) begin : g_int
      logic activeHigh, pinPrev, pinEdge;

      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) intCtrl[gi] <= '0;
        else if (regWr && regSel == SEL_W'(INT_BASE + gi)) intCtrl[gi] <= accIn;
      end

      assign activeHigh   = intCtrl[gi][LEVEL_BIT];
      assign levelHit[gi] = (intSync[gi] == activeHigh);

      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) pinPrev <= 1'b1;
        else       pinPrev <= intSync[gi];
      end

      assign pinEdge = activeHigh ? (~pinPrev & intSync[gi])
                                  : (pinPrev & ~intSync[gi]);

      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)                           exfFlag[gi] <= 1'b0;
        else if (exfClr[gi])                 exfFlag[gi] <= 1'b0;
        else if (strobes.runMode && pinEdge) exfFlag[gi] <= 1'b1;
      end
    end
  endgenerate

  assign wakeHit = strobes.armed & (keyFall | (|levelHit));

  // read-back to the accumulator
  always_comb begin
    accOut = '0;
    case (regSel)
      SEL_KEYEN_A: accOut = ACC_W'(keyEnA);
      SEL_KEYEN_B: accOut = ACC_W'(keyEnB);
      SEL_PULL_A:  accOut = ACC_W'(pullA);
      SEL_PULL_B:  accOut = ACC_W'(pullB);
      default: begin
        for (int i = 0; i < NUM_INT; i++)
          if (regSel == SEL_W'(INT_BASE + i)) accOut = intCtrl[i];
      end
    endcase
  end
endmodule

// File: rtl/wk_control.sv
module wk_control
  import wk_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      sleepEnter,
  input  logic      wakeAck,
  input  logic      wakeHit,
  output wkStrobe_t strobes,
  output logic      wakeReq
);
  wkState_e state, stateNext;

  always_comb begin
    stateNext = state;
    case (state)
      ST_RUN:   if (sleepEnter) stateNext = ST_SLEEP;
      ST_SLEEP: if (wakeHit)    stateNext = ST_WAKE;
      ST_WAKE:  if (wakeAck)    stateNext = ST_RUN;
      default:                  stateNext = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_RUN;
    else       state <= stateNext;
  end

  assign strobes.armed   = (state == ST_SLEEP);
  assign strobes.runMode = (state == ST_RUN);
  assign wakeReq         = (state == ST_WAKE);
endmodule

// File: rtl/wake_ctrl.sv
module wake_ctrl
  import wk_pkg::*;
#(
  parameter int KEY_W       = 4,
  parameter int NUM_INT     = 2,
  parameter int ACC_W       = 4,
  parameter int LEVEL_BIT   = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic               sampleClk,
  input  logic               rstN,
  input  logic [KEY_W-1:0]   keyPortA,
  input  logic [KEY_W-1:0]   keyPortB,
  input  logic [NUM_INT-1:0] intPin,
  input  logic               regWr,
  input  logic [2:0]         regSel,
  input  logic [ACC_W-1:0]   accIn,
  output logic [ACC_W-1:0]   accOut,
  input  logic [NUM_INT-1:0] exfClr,
  input  logic               sleepEnter,
  input  logic               wakeAck,
  output logic               wakeReq,
  output logic [2*KEY_W-1:0] pullEn,
  output logic [NUM_INT-1:0] exfFlag
);
  wkStrobe_t strobes;
  logic      wakeHit;

  wk_control u_ctrl (
    .clk(sampleClk), .rstN(rstN), .sleepEnter(sleepEnter), .wakeAck(wakeAck),
    .wakeHit(wakeHit), .strobes(strobes), .wakeReq(wakeReq)
  );

  wk_datapath #(
    .KEY_W(KEY_W), .NUM_INT(NUM_INT), .ACC_W(ACC_W),
    .LEVEL_BIT(LEVEL_BIT), .SYNC_STAGES(SYNC_STAGES)
  ) u_dp (
    .clk(sampleClk), .rstN(rstN), .keyA(keyPortA), .keyB(keyPortB),
    .intPin(intPin), .regWr(regWr), .regSel(regSel), .accIn(accIn),
    .exfClr(exfClr), .strobes(strobes), .accOut(accOut), .pullEn(pullEn),
    .exfFlag(exfFlag), .wakeHit(wakeHit)
  );
endmodule

// File: rtl/wake_ctrl_chk.sv
module wake_ctrl_chk #(
  parameter int KEY_W   = 4,
  parameter int NUM_INT = 2,
  parameter int ACC_W   = 4
) (
  input logic               clk,
  input logic               rstN,
  input logic               regWr,
  input logic [2:0]         regSel,
  input logic [ACC_W-1:0]   accIn,
  input logic [2*KEY_W-1:0] pullEn,
  input logic               wakeReq,
  input logic               wakeAck,
  input logic [NUM_INT-1:0] exfFlag,
  input logic               armed
);
  a_r1_reset_clear: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (pullEn == '0 && !wakeReq && exfFlag == '0));

  a_r3_pull_write: assert property (@(posedge clk) disable iff (!rstN)
    (regWr && regSel == 3'd2) |=> (pullEn[KEY_W-1:0] == $past(accIn[KEY_W-1:0])));

  a_r9_no_flag_in_sleep: assert property (@(posedge clk) disable iff (!rstN)
    armed |=> ((exfFlag & ~$past(exfFlag)) == '0));

  a_r10_wake_from_sleep: assert property (@(posedge clk) disable iff (!rstN)
    $rose(wakeReq) |-> $past(armed));

  a_r11_hold: assert property (@(posedge clk) disable iff (!rstN)
    (wakeReq && !wakeAck) |=> wakeReq);

  a_r11_release: assert property (@(posedge clk) disable iff (!rstN)
    (wakeReq && wakeAck) |=> !wakeReq);
endmodule

bind wake_ctrl wake_ctrl_chk #(.KEY_W(KEY_W), .NUM_INT(NUM_INT), .ACC_W(ACC_W)) u_chk (
  .clk(sampleClk), .rstN(rstN), .regWr(regWr), .regSel(regSel), .accIn(accIn),
  .pullEn(pullEn), .wakeReq(wakeReq), .wakeAck(wakeAck), .exfFlag(exfFlag),
  .armed(strobes.armed)
);

// File: tb/tb_wake_ctrl.sv
module tb_wake_ctrl;
  localparam time PERIOD = 10ns;

  logic       sampleClk = 1'b0;
  logic       rstN = 1'b0;
  logic [3:0] keyPortA = 4'hF, keyPortB = 4'hF;
  logic [1:0] intPin = 2'b11;
  logic       regWr = 1'b0;
  logic [2:0] regSel = 3'd0;
  logic [3:0] accIn = 4'h0;
  logic [3:0] accOut;
  logic [1:0] exfClr = 2'b00;
  logic       sleepEnter = 1'b0, wakeAck = 1'b0;
  logic       wakeReq;
  logic [7:0] pullEn;
  logic [1:0] exfFlag;

  int  checks = 0, errors = 0;
  bit  done = 1'b0;

  always #(PERIOD/2) sampleClk = ~sampleClk;

  wake_ctrl dut (
    .sampleClk(sampleClk), .rstN(rstN), .keyPortA(keyPortA), .keyPortB(keyPortB),
    .intPin(intPin), .regWr(regWr), .regSel(regSel), .accIn(accIn), .accOut(accOut),
    .exfClr(exfClr), .sleepEnter(sleepEnter), .wakeAck(wakeAck), .wakeReq(wakeReq),
    .pullEn(pullEn), .exfFlag(exfFlag)
  );

  task automatic checkEq(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge sampleClk);
  endtask

  task automatic writeReg(input logic [2:0] sel, input logic [3:0] val);
    @(negedge sampleClk);
    regSel = sel; accIn = val; regWr = 1'b1;
    @(negedge sampleClk);
    regWr = 1'b0;
  endtask

  task automatic readCheck(input logic [2:0] sel, input logic [3:0] exp, input string tag);
    regSel = sel;
    #1;
    checkEq(tag, accOut, exp);
  endtask

  task automatic enterSleep();
    @(negedge sampleClk); sleepEnter = 1'b1;
    @(negedge sampleClk); sleepEnter = 1'b0;
  endtask

  task automatic ackWake();
    @(negedge sampleClk); wakeAck = 1'b1;
    @(negedge sampleClk); wakeAck = 1'b0;
  endtask

  task automatic clearFlags();
    @(negedge sampleClk); exfClr = 2'b11;
    @(negedge sampleClk); exfClr = 2'b00;
  endtask

  task automatic tReset();
    checkEq("R1 wakeReq after reset", wakeReq, 0);
    checkEq("R1 exfFlag after reset", exfFlag, 0);
    checkEq("R1 pullEn after reset", pullEn, 0);
    for (int s = 0; s < 6; s++) readCheck(3'(s), 4'h0, "R1 register cleared");
  endtask

  task automatic tRegs();
    writeReg(3'd2, 4'hA);
    writeReg(3'd3, 4'h5);
    tick(1);
    checkEq("R3 pullEn mapping", pullEn, 8'h5A);
    readCheck(3'd2, 4'hA, "R2 readback pull A");
    readCheck(3'd3, 4'h5, "R2 readback pull B");
    writeReg(3'd4, 4'h6);
    writeReg(3'd5, 4'h9);
    writeReg(3'd1, 4'hC);
    readCheck(3'd4, 4'h6, "R2 readback ctrl 0");
    readCheck(3'd5, 4'h9, "R2 readback ctrl 1");
    readCheck(3'd1, 4'hC, "R2 readback keyen B");
    writeReg(3'd7, 4'hF);
    writeReg(3'd6, 4'hF);
    tick(1);
    readCheck(3'd7, 4'h0, "R2 unused code 7 reads 0");
    readCheck(3'd6, 4'h0, "R2 unused code 6 reads 0");
    checkEq("R2 unused write leaves pullEn", pullEn, 8'h5A);
    readCheck(3'd4, 4'h6, "R2 unused write leaves ctrl 0");
    writeReg(3'd1, 4'h0);
    writeReg(3'd4, 4'h0);
    writeReg(3'd5, 4'h0);
    writeReg(3'd2, 4'h0);
    writeReg(3'd3, 4'h0);
  endtask

  task automatic tExfRun();
    clearFlags();
    intPin[1] = 1'b0;            // falling edge, ctrl1 bit2 = 0
    tick(5);
    checkEq("R12 falling edge sets flag 1", exfFlag, 2'b10);
    @(negedge sampleClk); exfClr = 2'b10;
    @(negedge sampleClk); exfClr = 2'b00;
    checkEq("R12 clear flag 1", exfFlag, 2'b00);
    intPin[1] = 1'b1;
    tick(5);
    checkEq("R12 rising edge ignored when falling selected", exfFlag, 2'b00);
    writeReg(3'd5, 4'b0100);
    intPin[1] = 1'b0;
    tick(5);
    checkEq("R12 falling edge ignored when rising selected", exfFlag, 2'b00);
    intPin[1] = 1'b1;
    tick(5);
    checkEq("R12 rising edge sets flag 1", exfFlag, 2'b10);
    writeReg(3'd5, 4'b0000);
    clearFlags();
  endtask

  task automatic tKeyWake();
    writeReg(3'd0, 4'b0001);
    keyPortA[0] = 1'b0;
    tick(6);
    checkEq("R10 key fall in run mode", wakeReq, 0);
    keyPortA[0] = 1'b1;
    tick(5);
    enterSleep();
    tick(2);
    checkEq("R4 no wake before edge", wakeReq, 0);
    keyPortA[0] = 1'b0;
    tick(4);
    checkEq("R4 enabled key fall wakes", wakeReq, 1);
    tick(5);
    checkEq("R11 request held without ack", wakeReq, 1);
    ackWake();
    checkEq("R11 request drops after ack", wakeReq, 0);
    keyPortA[0] = 1'b1;
    tick(5);
  endtask

  task automatic tKeyRise();
    writeReg(3'd1, 4'b0010);
    keyPortB[1] = 1'b0;
    tick(5);
    enterSleep();
    tick(2);
    keyPortB[1] = 1'b1;
    tick(6);
    checkEq("R5 rising key edge no wake", wakeReq, 0);
    keyPortB[1] = 1'b0;
    tick(4);
    checkEq("R4 port B fall wakes", wakeReq, 1);
    ackWake();
    keyPortB[1] = 1'b1;
    tick(5);
  endtask

  task automatic tKeyDisabled();
    enterSleep();
    tick(2);
    keyPortB[2] = 1'b0;
    keyPortA[3] = 1'b0;
    tick(6);
    checkEq("R6 disabled pins ignored", wakeReq, 0);
    keyPortB[2] = 1'b1;
    keyPortA[3] = 1'b1;
    tick(3);
    keyPortA[0] = 1'b0;
    tick(4);
    checkEq("R6 enabled pin still wakes", wakeReq, 1);
    ackWake();
    keyPortA[0] = 1'b1;
    tick(5);
  endtask

  task automatic tKeyMask();
    writeReg(3'd0, 4'b0011);
    writeReg(3'd1, 4'b0000);
    keyPortA[0] = 1'b0;
    tick(5);
    enterSleep();
    tick(2);
    keyPortA[1] = 1'b0;
    tick(6);
    checkEq("R7 low enabled pin masks other fall", wakeReq, 0);
    keyPortA[1] = 1'b1;
    keyPortA[0] = 1'b1;
    tick(5);
    checkEq("R7 release to all-high no wake", wakeReq, 0);
    keyPortA[1] = 1'b0;
    tick(4);
    checkEq("R7 fall after all-high wakes", wakeReq, 1);
    ackWake();
    keyPortA[1] = 1'b1;
    writeReg(3'd0, 4'b0000);
    tick(5);
  endtask

  task automatic tIntLevel(input int idx, input logic activeHigh);
    writeReg(3'(4 + idx), activeHigh ? 4'b0100 : 4'b0000);
    intPin[idx] = ~activeHigh;
    tick(5);
    clearFlags();
    enterSleep();
    tick(3);
    checkEq($sformatf("R8 pin %0d idle level no wake", idx), wakeReq, 0);
    intPin[idx] = activeHigh;
    tick(4);
    checkEq($sformatf("R8 pin %0d level %0d wakes", idx, activeHigh), wakeReq, 1);
    checkEq($sformatf("R9 pin %0d flag clear in sleep", idx), exfFlag, 2'b00);
    ackWake();
    tick(4);
    checkEq($sformatf("R9 pin %0d flag clear after return", idx), exfFlag, 2'b00);
    intPin[idx] = ~activeHigh;
    tick(5);
  endtask

  initial begin
    #(PERIOD * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    tick(3);
    rstN = 1'b1;
    tick(1);
    tReset();
    tRegs();
    tExfRun();
    tKeyWake();
    tKeyRise();
    tKeyDisabled();
    tKeyMask();
    tIntLevel(0, 1'b1);
    tIntLevel(0, 1'b0);
    tIntLevel(1, 1'b1);
    tIntLevel(1, 1'b0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule